// File: doc/BRIEF.md
# ADC Trigger Event Selector for PWM Channel Pairs

This block turns time-base and comparator events of a PWM generator into start-of-conversion pulses for an ADC. The PWM channels are grouped in pairs, even and odd. Each pair has its own 4-bit condition code, its own enable and its own sticky flag. The condition code picks one event source. The choices are the even counter reaching zero, the even counter reaching its period, either of those two, a compare match on the even channel while counting up or counting down, or a compare match on the odd channel while counting up or counting down.

The event inputs are single-cycle strobes from the counter and comparator logic. When the selected strobe of an enabled pair is high, the pair's trigger output is high in that same cycle. On the next cycle the pair's flag becomes set. The flag stays set until software clears it. The number of pairs and the selector width are parameters.

Top module: `adct_trig_sel`

## Requirements
- R1: With condition code 0, the pair triggers on the even-channel zero strobe and on no other strobe.
- R2: With condition code 1, the pair triggers on the even-channel period strobe and on no other strobe.
- R3: With condition code 2, the pair triggers on either the even-channel zero strobe or the even-channel period strobe, and on no other strobe.
- R4: With condition code 3, the pair triggers only on the even up-count compare strobe. With code 4, it triggers only on the even down-count compare strobe.
- R5: With condition code 8, the pair triggers only on the odd up-count compare strobe. With code 9, it triggers only on the odd down-count compare strobe.
- R6: Codes 5, 6, 7 and 10 through 15 never produce a trigger or set the flag.
- R7: While a pair's enable is low, its trigger output stays low and its flag does not get set, whatever its strobes do.
- R8: The trigger output is high in the same cycle as the selected strobe. The flag reads 1 from the following cycle on, and keeps that value while no clear is requested.
- R9: A clear request with no trigger in the same cycle makes the flag read 0 in the next cycle.
- R10: A clear request in the same cycle as a trigger leaves the flag set.
- R11: Each pair uses only its own strobes, condition code, enable and clear.
- R12: After reset, all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_even_zero | input | NUM_PAIRS | Even counter at zero, one bit per pair |
| evt_even_prd | input | NUM_PAIRS | Even counter at its period, one bit per pair |
| evt_even_cmp_up | input | NUM_PAIRS | Even compare match while counting up |
| evt_even_cmp_dn | input | NUM_PAIRS | Even compare match while counting down |
| evt_odd_cmp_up | input | NUM_PAIRS | Odd compare match while counting up |
| evt_odd_cmp_dn | input | NUM_PAIRS | Odd compare match while counting down |
| trig_en | input | NUM_PAIRS | Trigger enable per pair |
| trig_sel | input | NUM_PAIRS*SEL_W | Condition code per pair; pair i uses bits [i*SEL_W +: SEL_W] |
| flag_clr | input | NUM_PAIRS | Flag clear request per pair |
| adc_trig | output | NUM_PAIRS | Start-of-conversion pulse per pair |
| trig_flag | output | NUM_PAIRS | Sticky trigger flag per pair |

## Verification
The hardest case to reach is a clear request landing in the exact cycle that a new trigger fires. The bench reaches it by setting the flag first. It then drives the selected strobe and the clear in the same cycle, and reads the flag one cycle later. The bench also checks the reserved and non-matching codes. It sweeps all sixteen codes against each of the six strobes, one strobe at a time. A wrong code decode therefore shows up as a wrong pulse or a wrong flag for one specific code and strobe pair.

// File: rtl/adct_pkg.sv
package adct_pkg;

   // Event strobes of one channel pair
   typedef struct packed {
      logic odd_cmp_dn;
      logic odd_cmp_up;
      logic even_cmp_dn;
      logic even_cmp_up;
      logic even_prd;
      logic even_zero;
   } adct_evt_t;

   // Condition codes (behavioural encoding)
   localparam int unsigned COND_ZERO      = 0;
   localparam int unsigned COND_PRD       = 1;
   localparam int unsigned COND_ZERO_PRD  = 2;
   localparam int unsigned COND_EVEN_UP   = 3;
   localparam int unsigned COND_EVEN_DN   = 4;
   localparam int unsigned COND_ODD_UP    = 8;
   localparam int unsigned COND_ODD_DN    = 9;
   localparam int unsigned COND_MIN_WIDTH = 4;

endpackage

// File: rtl/adct_event_mux.sv
module adct_event_mux
   import adct_pkg::*;
#(
   parameter int unsigned SEL_W = 4
) (
   input  adct_evt_t        evt_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             en_i,
   output logic             hit_o
);

   logic chosen;

   always_comb begin
      chosen = 1'b0;
      if (sel_i == SEL_W'(COND_ZERO))          chosen = evt_i.even_zero;
      else if (sel_i == SEL_W'(COND_PRD))      chosen = evt_i.even_prd;
      else if (sel_i == SEL_W'(COND_ZERO_PRD)) chosen = evt_i.even_zero | evt_i.even_prd;
      else if (sel_i == SEL_W'(COND_EVEN_UP))  chosen = evt_i.even_cmp_up;
      else if (sel_i == SEL_W'(COND_EVEN_DN))  chosen = evt_i.even_cmp_dn;
      else if (sel_i == SEL_W'(COND_ODD_UP))   chosen = evt_i.odd_cmp_up;
      else if (sel_i == SEL_W'(COND_ODD_DN))   chosen = evt_i.odd_cmp_dn;
      else                                     chosen = 1'b0;
   end

   assign hit_o = en_i & chosen;

endmodule

// File: rtl/adct_flag.sv
module adct_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);

   // R10
   flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i) |=> flag_o);

endmodule

// File: rtl/adct_trig_sel.sv
module adct_trig_sel
   import adct_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 3,
   parameter int unsigned SEL_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PAIRS-1:0]       evt_even_zero,
   input  logic [NUM_PAIRS-1:0]       evt_even_prd,
   input  logic [NUM_PAIRS-1:0]       evt_even_cmp_up,
   input  logic [NUM_PAIRS-1:0]       evt_even_cmp_dn,
   input  logic [NUM_PAIRS-1:0]       evt_odd_cmp_up,
   input  logic [NUM_PAIRS-1:0]       evt_odd_cmp_dn,
   input  logic [NUM_PAIRS-1:0]       trig_en,
   input  logic [NUM_PAIRS*SEL_W-1:0] trig_sel,
   input  logic [NUM_PAIRS-1:0]       flag_clr,
   output logic [NUM_PAIRS-1:0]       adc_trig,
   output logic [NUM_PAIRS-1:0]       trig_flag
);

   localparam int unsigned SEL_TOTAL = NUM_PAIRS * SEL_W;

   // Elaboration checks on parameters
   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("adct_trig_sel: NUM_PAIRS must be at least 1");
   end
   if (SEL_W < COND_MIN_WIDTH) begin : g_bad_sel
      $error("adct_trig_sel: SEL_W must hold the odd-channel codes");
   end
   if (SEL_TOTAL != $bits(trig_sel)) begin : g_bad_total
      $error("adct_trig_sel: selector bus width mismatch");
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      adct_evt_t        evt;
      logic [SEL_W-1:0] sel;
      logic             reserved;

      assign evt.even_zero   = evt_even_zero[p];
      assign evt.even_prd    = evt_even_prd[p];
      assign evt.even_cmp_up = evt_even_cmp_up[p];
      assign evt.even_cmp_dn = evt_even_cmp_dn[p];
      assign evt.odd_cmp_up  = evt_odd_cmp_up[p];
      assign evt.odd_cmp_dn  = evt_odd_cmp_dn[p];
      assign sel             = trig_sel[p*SEL_W +: SEL_W];

      assign reserved = !(sel <= SEL_W'(COND_EVEN_DN) ||
                          sel == SEL_W'(COND_ODD_UP)  ||
                          sel == SEL_W'(COND_ODD_DN));

      adct_event_mux #(.SEL_W(SEL_W)) u_mux (
         .evt_i (evt),
         .sel_i (sel),
         .en_i  (trig_en[p]),
         .hit_o (adc_trig[p])
      );

      adct_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (adc_trig[p]),
         .clr_i  (flag_clr[p]),
         .flag_o (trig_flag[p])
      );

      // R6
      reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
         reserved |-> !adc_trig[p]);

      // R7
      disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !trig_en[p] |-> !adc_trig[p]);

      // R11
      needs_own_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
         adc_trig[p] |-> (evt != '0));

      // R7
      disabled_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!trig_en[p] && !trig_flag[p]) |=> !trig_flag[p]);
   end

endmodule

// File: tb/tb_adct_trig_sel.sv
module tb_adct_trig_sel;
   localparam int NP = 3;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] ez = '0, ep = '0, ecu = '0, ecd = '0, ocu = '0, ocd = '0;
   logic [NP-1:0] en = '0, clr = '0;
   logic [NP*SW-1:0] sel = '0;
   logic [NP-1:0] trig, flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   adct_trig_sel #(.NUM_PAIRS(NP), .SEL_W(SW)) dut (
      .clk(clk), .rst_n(rst_n),
      .evt_even_zero(ez), .evt_even_prd(ep),
      .evt_even_cmp_up(ecu), .evt_even_cmp_dn(ecd),
      .evt_odd_cmp_up(ocu), .evt_odd_cmp_dn(ocd),
      .trig_en(en), .trig_sel(sel), .flag_clr(clr),
      .adc_trig(trig), .trig_flag(flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // event bits: 0 even zero, 1 even period, 2 even up cmp, 3 even down cmp, 4 odd up cmp, 5 odd down cmp
   function automatic bit expect_hit(input int code, input int ev);
      case (code)
         0: return ev == 0;
         1: return ev == 1;
         2: return ev == 0 || ev == 1;
         3: return ev == 2;
         4: return ev == 3;
         8: return ev == 4;
         9: return ev == 5;
         default: return 0;
      endcase
   endfunction

   function automatic string code_req(input int code);
      case (code)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3, 4: return "R4";
         8, 9: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic set_ev(input int p, input logic [5:0] ev);
      ez[p] = ev[0]; ep[p] = ev[1]; ecu[p] = ev[2];
      ecd[p] = ev[3]; ocu[p] = ev[4]; ocd[p] = ev[5];
   endtask

   // Called at a negedge: drives one cycle of strobes/clear, checks pulse, returns at next negedge
   task automatic cycle(input int p, input logic [5:0] ev, input bit c,
                        input bit exp_trig, input string req);
      set_ev(p, ev);
      clr[p] = c;
      #1;
      check(trig[p] == exp_trig, req, trig[p], exp_trig);
      @(negedge clk);
      set_ev(p, 6'b0);
      clr[p] = 1'b0;
   endtask

   task automatic clear_flag(input int p);
      cycle(p, 6'b0, 1'b1, 1'b0, "R9");
   endtask

   task automatic t_reset;
      check(flag == '0, "R12", flag, 0);
      check(trig == '0, "R12", trig, 0);
   endtask

   task automatic t_code_sweep;
      en[0] = 1'b1;
      for (int code = 0; code < 16; code++) begin
         sel[0 +: SW] = SW'(code);
         for (int ev = 0; ev < 6; ev++) begin
            bit e;
            e = expect_hit(code, ev);
            cycle(0, 6'(1 << ev), 1'b0, e, code_req(code));
            check(flag[0] == e, code_req(code), flag[0], e);
            if (flag[0]) clear_flag(0);
         end
      end
   endtask

   task automatic t_disabled;
      en[0] = 1'b0;
      sel[0 +: SW] = SW'(2);
      cycle(0, 6'b111111, 1'b0, 1'b0, "R7");
      check(flag[0] == 1'b0, "R7", flag[0], 0);
      en[0] = 1'b1;
   endtask

   task automatic t_sticky_and_clear;
      sel[0 +: SW] = SW'(1);
      cycle(0, 6'b000010, 1'b0, 1'b1, "R8");
      for (int i = 0; i < 4; i++) begin
         check(flag[0] == 1'b1, "R8", flag[0], 1);
         @(negedge clk);
      end
      cycle(0, 6'b0, 1'b1, 1'b0, "R9");
      check(flag[0] == 1'b0, "R9", flag[0], 0);
   endtask

   task automatic t_clear_collision;
      sel[0 +: SW] = SW'(8);
      cycle(0, 6'b010000, 1'b0, 1'b1, "R10");
      check(flag[0] == 1'b1, "R10", flag[0], 1);
      cycle(0, 6'b010000, 1'b1, 1'b1, "R10");
      check(flag[0] == 1'b1, "R10", flag[0], 1);
      clear_flag(0);
      check(flag[0] == 1'b0, "R10", flag[0], 0);
      // collision from a clear flag also ends set
      cycle(0, 6'b010000, 1'b1, 1'b1, "R10");
      check(flag[0] == 1'b1, "R10", flag[0], 1);
      clear_flag(0);
   endtask

   task automatic t_independence;
      en = '1;
      sel = {SW'(9), SW'(3), SW'(0)};
      // pair 1 even-up strobe: only pair 1 fires
      ecu[1] = 1'b1; ez[2] = 1'b1;
      #1;
      check(trig == 3'b010, "R11", trig, 3'b010);
      @(negedge clk);
      ecu[1] = 1'b0; ez[2] = 1'b0;
      check(flag == 3'b010, "R11", flag, 3'b010);
      // clear on pair 2 does not touch pair 1
      cycle(2, 6'b0, 1'b1, 1'b0, "R11");
      check(flag == 3'b010, "R11", flag, 3'b010);
      cycle(2, 6'b100000, 1'b0, 1'b1, "R11");
      check(flag == 3'b110, "R11", flag, 3'b110);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_code_sweep();
      t_disabled();
      t_sticky_and_clear();
      t_clear_collision();
      t_independence();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule